// File: doc/BRIEF.md
# Interrupt Pin Router with Level Acknowledge

This block turns a bank of interrupt lines into delivery messages for processors. Each line has a routing entry in a redirection table. Software owns the table, so the block receives every field of it as an input vector. The fields are the vector, the destination ID, the destination mode, the delivery mode, the trigger kind, the polarity and the mask. The block forms the effective level of each line and detects the requests the line raises. A request is either queued for delivery or reported as coalesced. Queued requests are emitted one at a time on a valid/ready message port.

Level-triggered lines use a remote-IRR bit per pin. Delivering a request sets the bit. While the bit is set, further requests on that pin are held back. A level-type end-of-interrupt (EOI) notice whose vector matches the entry releases the bit. Pin 0 is always routed to a fixed boot processor. The block also keeps a 256-bit map of every vector held in any table entry. Software signals each table update with a write strobe, and the map is refreshed on that strobe. Line arbitration uses a two-state FSM. In `ARB_IDLE` the FSM waits for a queued request. The *grant* transition to `ARB_OFFER` happens when any request is queued, and it captures the payload of the lowest queued pin. The *retire* transition back to `ARB_IDLE` happens on the handshake, and it drops that pin's queued request.

Top module: `irq_router`

## Requirements
- R1: The effective level of a pin is its line XOR its polarity bit. An input event is a 0-to-1 change of the effective level. The pending bit follows the effective level, so an inactive level clears it.
- R2: On an edge-triggered pin, an event is delivered when that pin has no request waiting. If a request is still waiting, the event is coalesced and no extra message is produced.
- R3: On a level-triggered pin, an event is delivered when remote-IRR is clear, and delivery sets remote-IRR. If remote-IRR is set, the event is coalesced.
- R4: An event on a masked entry produces no message, no delivered pulse and no remote-IRR.
- R5: A message copies these entry fields: destination ID, destination mode (0 = physical), vector, trigger (1 = level) and the 3-bit delivery mode. The payload does not change while `msg_valid` is high and `msg_ready` is low.
- R6: A message from pin 0 always carries `boot_id` as destination and destination mode 0, whatever the entry holds.
- R7: An EOI with `eoi_level`=1 is matched against the vector of every entry. Each matching entry has remote-IRR cleared. A matching entry that is level-triggered, unmasked and has its pending bit set is serviced again. An EOI with `eoi_level`=0, or one whose vector matches no entry, changes nothing.
- R8: A write strobe for a level-triggered entry whose pending bit is set services that entry again at once. With `wr_low`=1 the strobe clears remote-IRR first. With `wr_low`=0 remote-IRR is kept.
- R9: When several requests are queued, the lowest pin index is sent first. Only one message is offered at a time. The next message is offered after the handshake.
- R10: Bit v of `vec_map` is 1 exactly when some entry holds vector v. The map is refreshed on each write strobe and once just after reset. It reads zero during reset.
- R11: `st_dlv` and `st_coal` each have one bit per pin. A bit pulses for one cycle, in the cycle after the clock edge that samples the event. The two outputs are never both high for the same pin.
- R12: During reset no message is offered, both status outputs are zero, and the pending, remote-IRR and queue state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | NPINS | Raw interrupt line levels |
| tbl_mask | input | NPINS | Per-entry mask bit |
| tbl_level | input | NPINS | Per-entry trigger kind, 1 = level |
| tbl_pol | input | NPINS | Per-entry polarity, 1 = active low |
| tbl_dmode | input | NPINS | Per-entry destination mode, 0 = physical |
| tbl_vec | input | NPINS*8 | Per-entry vector, pin i at bits [8i+7:8i] |
| tbl_dest | input | NPINS*8 | Per-entry destination ID |
| tbl_dlv | input | NPINS*3 | Per-entry delivery mode |
| wr_strobe | input | 1 | One-cycle notice that an entry was rewritten |
| wr_pin | input | PIN_W | Index of the rewritten entry |
| wr_low | input | 1 | The rewrite touched the low half, which clears remote-IRR |
| boot_id | input | 8 | Destination ID of the boot processor |
| eoi_valid | input | 1 | One-cycle EOI notice |
| eoi_vec | input | 8 | Vector carried by the EOI |
| eoi_level | input | 1 | EOI is level-type |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The consumer takes the message |
| msg_dest | output | 8 | Message destination ID |
| msg_dmode | output | 1 | Message destination mode |
| msg_vec | output | 8 | Message vector |
| msg_level | output | 1 | Message trigger kind |
| msg_dlv | output | 3 | Message delivery mode |
| vec_map | output | 256 | Map of the vectors held in the table |
| st_dlv | output | NPINS | Per-pin pulse: the event was delivered |
| st_coal | output | NPINS | Per-pin pulse: the event was coalesced |

## Verification
The assertions take the following inputs for granted:
- `wr_pin` addresses an existing entry.
- EOI notices and write strobes are single-cycle pulses.
- `boot_id` is valid in the cycle of a grant.
- Table fields change only together with a write strobe.

The stimulus honours these assumptions. It changes polarity only together with a line level that keeps the effective level inactive. It sends every table change with a strobe, and it keeps `boot_id` constant.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int DLV_W  = 3;
    localparam int NVEC   = 1 << VEC_W;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dmode;
        logic [VEC_W-1:0]  vec;
        logic              level;
        logic [DLV_W-1:0]  dlv;
    } irq_msg_t;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_e;

endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] line_in,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] pend,
    output logic [NPINS-1:0] rise
);

    logic [NPINS-1:0] eff;

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_pin
            assign eff[g]  = line_in[g] ^ pol[g];
            assign rise[g] = eff[g] & ~pend[g];
        end
    endgenerate

    // The pending bit tracks the effective level; an inactive level clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= eff;
        end
    end

endmodule

// File: rtl/irq_svc_ctrl.sv
module irq_svc_ctrl
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       rise,
    input  logic [NPINS-1:0]       pend,
    input  logic [NPINS-1:0]       mask,
    input  logic [NPINS-1:0]       level,
    input  logic [NPINS*VEC_W-1:0] vec_flat,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vec,
    input  logic                   eoi_level,
    input  logic                   wr_strobe,
    input  logic [PIN_W-1:0]       wr_pin,
    input  logic                   wr_low,
    input  logic [NPINS-1:0]       clr,
    output logic [NPINS-1:0]       q,
    output logic [NPINS-1:0]       rirr,
    output logic [NPINS-1:0]       st_dlv,
    output logic [NPINS-1:0]       st_coal
);

    logic [NPINS-1:0] q_nx;
    logic [NPINS-1:0] rirr_nx;
    logic [NPINS-1:0] dlv_nx;
    logic [NPINS-1:0] coal_nx;

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_svc
            logic [VEC_W-1:0] vec_g;
            logic             eoi_hit;
            logic             wr_hit;
            logic             rirr_kept;
            logic             coal;
            logic             svc;
            logic             fire;

            assign vec_g     = vec_flat[g*VEC_W +: VEC_W];
            assign eoi_hit   = eoi_valid & eoi_level & (vec_g == eoi_vec);
            assign wr_hit    = wr_strobe & (wr_pin == PIN_W'(g));
            // Remote-IRR after this cycle's acknowledge and low-half rewrite.
            assign rirr_kept = rirr[g] & ~eoi_hit & ~(wr_hit & wr_low);
            // Edge pins coalesce on a waiting request, level pins on remote-IRR.
            assign coal      = rise[g] & (level[g] ? rirr_kept : q[g]);
            assign svc       = (rise[g] & ~coal)
                             | (eoi_hit & level[g] & pend[g])
                             | (wr_hit & level[g] & pend[g]);
            assign fire      = svc & ~mask[g];

            assign q_nx[g]    = (q[g] & ~clr[g]) | fire;
            assign rirr_nx[g] = rirr_kept | (fire & level[g]);
            assign dlv_nx[g]  = rise[g] & ~coal & ~mask[g];
            assign coal_nx[g] = coal;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            rirr    <= '0;
            st_dlv  <= '0;
            st_coal <= '0;
        end else begin
            q       <= q_nx;
            rirr    <= rirr_nx;
            st_dlv  <= dlv_nx;
            st_coal <= coal_nx;
        end
    end

endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int PIN_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        q,
    input  logic [NPINS*DEST_W-1:0] dest_flat,
    input  logic [NPINS-1:0]        dmode,
    input  logic [NPINS*VEC_W-1:0]  vec_flat,
    input  logic [NPINS-1:0]        level,
    input  logic [NPINS*DLV_W-1:0]  dlv_flat,
    input  logic [DEST_W-1:0]       boot_id,
    input  logic                    msg_ready,
    output logic                    msg_valid,
    output irq_msg_t                msg,
    output logic [NPINS-1:0]        clr,
    output logic [PIN_W-1:0]        cur_pin
);

    arb_state_e       state;
    arb_state_e       state_nx;
    logic [PIN_W-1:0] pick;
    logic             any;
    irq_msg_t         cand;

    // Lowest queued pin wins.
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (q[i]) begin
                pick = PIN_W'(i);
                any  = 1'b1;
            end
        end
    end

    always_comb begin
        cand.dest  = dest_flat[pick*DEST_W +: DEST_W];
        cand.dmode = dmode[pick];
        cand.vec   = vec_flat[pick*VEC_W +: VEC_W];
        cand.level = level[pick];
        cand.dlv   = dlv_flat[pick*DLV_W +: DLV_W];
        if (pick == '0) begin
            cand.dest  = boot_id;
            cand.dmode = 1'b0;
        end
    end

    always_comb begin
        unique case (state)
            ARB_IDLE:  state_nx = any ? ARB_OFFER : ARB_IDLE;
            ARB_OFFER: state_nx = msg_ready ? ARB_IDLE : ARB_OFFER;
            default:   state_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg     <= '0;
            cur_pin <= '0;
        end else if (state == ARB_IDLE && any) begin
            msg     <= cand;
            cur_pin <= pick;
        end
    end

    always_comb begin
        msg_valid = (state == ARB_OFFER);
        clr       = (msg_valid && msg_ready) ? (NPINS'(1) << cur_pin) : '0;
    end

endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS*VEC_W-1:0] vec_flat,
    input  logic                   refresh,
    output logic [NVEC-1:0]        map
);

    logic            init_done;
    logic [NVEC-1:0] map_nx;

    always_comb begin
        map_nx = '0;
        for (int i = 0; i < NPINS; i++) begin
            map_nx[vec_flat[i*VEC_W +: VEC_W]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_done <= 1'b0;
            map       <= '0;
        end else begin
            init_done <= 1'b1;
            if (refresh || !init_done) begin
                map <= map_nx;
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        line_in,
    input  logic [NPINS-1:0]        tbl_mask,
    input  logic [NPINS-1:0]        tbl_level,
    input  logic [NPINS-1:0]        tbl_pol,
    input  logic [NPINS-1:0]        tbl_dmode,
    input  logic [NPINS*VEC_W-1:0]  tbl_vec,
    input  logic [NPINS*DEST_W-1:0] tbl_dest,
    input  logic [NPINS*DLV_W-1:0]  tbl_dlv,
    input  logic                    wr_strobe,
    input  logic [PIN_W-1:0]        wr_pin,
    input  logic                    wr_low,
    input  logic [DEST_W-1:0]       boot_id,
    input  logic                    eoi_valid,
    input  logic [VEC_W-1:0]        eoi_vec,
    input  logic                    eoi_level,
    output logic                    msg_valid,
    input  logic                    msg_ready,
    output logic [DEST_W-1:0]       msg_dest,
    output logic                    msg_dmode,
    output logic [VEC_W-1:0]        msg_vec,
    output logic                    msg_level,
    output logic [DLV_W-1:0]        msg_dlv,
    output logic [NVEC-1:0]         vec_map,
    output logic [NPINS-1:0]        st_dlv,
    output logic [NPINS-1:0]        st_coal
);

    logic [NPINS-1:0] pend_lvl;
    logic [NPINS-1:0] rise_evt;
    logic [NPINS-1:0] q_pend;
    logic [NPINS-1:0] rirr_st;
    logic [NPINS-1:0] grant_clr;
    logic [PIN_W-1:0] grant_pin;
    irq_msg_t         msg_q;

    irq_pin_sense #(.NPINS(NPINS)) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .pol     (tbl_pol),
        .pend    (pend_lvl),
        .rise    (rise_evt)
    );

    irq_svc_ctrl #(.NPINS(NPINS), .PIN_W(PIN_W)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise_evt),
        .pend      (pend_lvl),
        .mask      (tbl_mask),
        .level     (tbl_level),
        .vec_flat  (tbl_vec),
        .eoi_valid (eoi_valid),
        .eoi_vec   (eoi_vec),
        .eoi_level (eoi_level),
        .wr_strobe (wr_strobe),
        .wr_pin    (wr_pin),
        .wr_low    (wr_low),
        .clr       (grant_clr),
        .q         (q_pend),
        .rirr      (rirr_st),
        .st_dlv    (st_dlv),
        .st_coal   (st_coal)
    );

    irq_msg_arb #(.NPINS(NPINS), .PIN_W(PIN_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .q         (q_pend),
        .dest_flat (tbl_dest),
        .dmode     (tbl_dmode),
        .vec_flat  (tbl_vec),
        .level     (tbl_level),
        .dlv_flat  (tbl_dlv),
        .boot_id   (boot_id),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg       (msg_q),
        .clr       (grant_clr),
        .cur_pin   (grant_pin)
    );

    irq_vec_map #(.NPINS(NPINS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .vec_flat (tbl_vec),
        .refresh  (wr_strobe),
        .map      (vec_map)
    );

    assign msg_dest  = msg_q.dest;
    assign msg_dmode = msg_q.dmode;
    assign msg_vec   = msg_q.vec;
    assign msg_level = msg_q.level;
    assign msg_dlv   = msg_q.dlv;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NPINS = 24,
    parameter int PIN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] tbl_mask,
    input logic [NPINS-1:0] tbl_level,
    input logic [7:0]       boot_id,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [7:0]       msg_dest,
    input logic             msg_dmode,
    input logic [7:0]       msg_vec,
    input logic             msg_level,
    input logic [2:0]       msg_dlv,
    input logic [NPINS-1:0] st_dlv,
    input logic [NPINS-1:0] st_coal,
    input logic [NPINS-1:0] q_pend,
    input logic [NPINS-1:0] rirr_st,
    input logic [PIN_W-1:0] grant_pin
);

    assert_msg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
            (msg_valid && $stable({msg_dest, msg_dmode, msg_vec, msg_level, msg_dlv})));

    assert_boot_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msg_valid) && grant_pin == '0) |->
            (msg_dmode == 1'b0 && msg_dest == $past(boot_id)));

    assert_rirr_level_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rirr_st & ~$past(rirr_st) & ~$past(tbl_level)) == '0));

    assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_dlv & $past(tbl_mask)) == '0));

    assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_dlv & st_coal) == '0));

    assert_edge_coal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_coal & ~$past(tbl_level) & ~$past(q_pend)) == '0));

    assert_lowest_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |->
            (($past(q_pend) & ((NPINS'(1) << grant_pin) - NPINS'(1))) == '0));

    assert_retire_on_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msg_valid) |-> $past(msg_ready));

endmodule

bind irq_router irq_route_chk #(.NPINS(NPINS), .PIN_W(PIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tbl_mask  (tbl_mask),
    .tbl_level (tbl_level),
    .boot_id   (boot_id),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_dest  (msg_dest),
    .msg_dmode (msg_dmode),
    .msg_vec   (msg_vec),
    .msg_level (msg_level),
    .msg_dlv   (msg_dlv),
    .st_dlv    (st_dlv),
    .st_coal   (st_coal),
    .q_pend    (q_pend),
    .rirr_st   (rirr_st),
    .grant_pin (grant_pin)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;

    localparam int NP = 24;
    localparam logic [7:0] BOOT = 8'h2A;

    typedef struct packed {
        logic [4:0] pin;
        logic       lvl;
        logic       pol;
        logic       msk;
        logic       dm;
        logic [7:0] vec;
        logic [7:0] dst;
        logic [2:0] dlv;
    } row_t;

    localparam int NROWS = 6;
    localparam row_t ROWS [NROWS] = '{
        '{5'd2,  1'b0, 1'b0, 1'b0, 1'b1, 8'h31, 8'h05, 3'd1},
        '{5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 8'h20, 8'h0F, 3'd2},
        '{5'd7,  1'b1, 1'b1, 1'b0, 1'b0, 8'h41, 8'h03, 3'd0},
        '{5'd9,  1'b0, 1'b0, 1'b1, 1'b0, 8'h50, 8'h01, 3'd0},
        '{5'd23, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFE, 8'h80, 3'd7},
        '{5'd12, 1'b1, 1'b0, 1'b1, 1'b0, 8'h60, 8'h02, 3'd4}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   line_in = '0;
    logic [NP-1:0]   tbl_mask = '1;
    logic [NP-1:0]   tbl_level = '0;
    logic [NP-1:0]   tbl_pol = '0;
    logic [NP-1:0]   tbl_dmode = '0;
    logic [NP*8-1:0] tbl_vec = '0;
    logic [NP*8-1:0] tbl_dest = '0;
    logic [NP*3-1:0] tbl_dlv = '0;
    logic            wr_strobe = 1'b0;
    logic [4:0]      wr_pin = '0;
    logic            wr_low = 1'b0;
    logic            eoi_valid = 1'b0;
    logic [7:0]      eoi_vec = '0;
    logic            eoi_level = 1'b0;
    logic            msg_ready = 1'b0;
    logic            msg_valid;
    logic [7:0]      msg_dest;
    logic            msg_dmode;
    logic [7:0]      msg_vec;
    logic            msg_level;
    logic [2:0]      msg_dlv;
    logic [255:0]    vec_map;
    logic [NP-1:0]   st_dlv;
    logic [NP-1:0]   st_coal;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_router #(.NPINS(NP)) i_irq_router (
        .clk (clk), .rst_n (rst_n), .line_in (line_in),
        .tbl_mask (tbl_mask), .tbl_level (tbl_level), .tbl_pol (tbl_pol),
        .tbl_dmode (tbl_dmode), .tbl_vec (tbl_vec), .tbl_dest (tbl_dest),
        .tbl_dlv (tbl_dlv), .wr_strobe (wr_strobe), .wr_pin (wr_pin),
        .wr_low (wr_low), .boot_id (BOOT), .eoi_valid (eoi_valid),
        .eoi_vec (eoi_vec), .eoi_level (eoi_level), .msg_valid (msg_valid),
        .msg_ready (msg_ready), .msg_dest (msg_dest), .msg_dmode (msg_dmode),
        .msg_vec (msg_vec), .msg_level (msg_level), .msg_dlv (msg_dlv),
        .vec_map (vec_map), .st_dlv (st_dlv), .st_coal (st_coal)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int p, input logic lv, input logic pl, input logic mk,
                       input logic dm, input logic [7:0] v, input logic [7:0] d, input logic [2:0] dl);
        @(negedge clk);
        tbl_level[p] = lv;
        tbl_pol[p]   = pl;
        line_in[p]   = pl;
        tbl_mask[p]  = mk;
        tbl_dmode[p] = dm;
        tbl_vec[p*8 +: 8]  = v;
        tbl_dest[p*8 +: 8] = d;
        tbl_dlv[p*3 +: 3]  = dl;
        wr_strobe = 1'b1;
        wr_pin    = 5'(p);
        wr_low    = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic wr_pulse(input int p, input logic lo);
        @(negedge clk);
        wr_strobe = 1'b1;
        wr_pin    = 5'(p);
        wr_low    = lo;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v, input logic lv);
        @(negedge clk);
        eoi_valid = 1'b1;
        eoi_vec   = v;
        eoi_level = lv;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic drive_line(input int p, input logic val);
        @(negedge clk);
        line_in[p] = val;
    endtask

    task automatic wait_msg(input string tag, input logic [20:0] exp);
        int k = 0;
        while (!msg_valid && k < 8) begin
            @(negedge clk);
            k++;
        end
        chk(msg_valid, tag, 64'(msg_valid), 64'd1);
        chk({msg_dest, msg_dmode, msg_vec, msg_level, msg_dlv} == exp, tag,
            64'({msg_dest, msg_dmode, msg_vec, msg_level, msg_dlv}), 64'(exp));
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic no_msg(input string tag, input int n);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        chk(!seen, tag, 64'(seen), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R12 / R10: reset state
        repeat (2) @(negedge clk);
        chk(msg_valid == 1'b0, "R12 reset msg_valid", 64'(msg_valid), 64'd0);
        chk(st_dlv == '0 && st_coal == '0, "R12 reset status", 64'(st_dlv | st_coal), 64'd0);
        chk(vec_map == '0, "R10 map zero in reset", 64'(vec_map[63:0]), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(vec_map == 256'h1, "R10 map after reset", 64'(vec_map[63:0]), 64'd1);

        // Table walk: R1 polarity, R4 mask, R5 fields, R6 boot route, R11 pulse
        for (int r = 0; r < NROWS; r++) begin
            row_t rw;
            logic [20:0] expm;
            rw = ROWS[r];
            cfg(int'(rw.pin), rw.lvl, rw.pol, rw.msk, rw.dm, rw.vec, rw.dst, rw.dlv);
            drive_line(int'(rw.pin), ~rw.pol);
            @(negedge clk);
            chk(st_dlv[rw.pin] == ~rw.msk, "R1 R4 delivered pulse", 64'(st_dlv[rw.pin]), 64'(~rw.msk));
            chk(st_coal[rw.pin] == 1'b0, "R11 no coalesce", 64'(st_coal[rw.pin]), 64'd0);
            @(negedge clk);
            chk(st_dlv == '0, "R11 one-cycle pulse", 64'(st_dlv), 64'd0);
            if (rw.pin == 5'd0)
                expm = {BOOT, 1'b0, rw.vec, rw.lvl, rw.dlv};
            else
                expm = {rw.dst, rw.dm, rw.vec, rw.lvl, rw.dlv};
            if (!rw.msk) wait_msg((rw.pin == 5'd0) ? "R6 boot route" : "R5 message fields", expm);
            else no_msg("R4 masked silent", 6);
            drive_line(int'(rw.pin), rw.pol);
            if (rw.lvl) eoi(rw.vec, 1'b1);
            cfg(int'(rw.pin), 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 3'd0);
        end

        // R9: two simultaneous requests, lowest pin first
        cfg(3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h13, 8'h33, 3'd1);
        cfg(5, 1'b0, 1'b0, 1'b0, 1'b1, 8'h15, 8'h55, 3'd1);
        @(negedge clk);
        line_in[3] = 1'b1;
        line_in[5] = 1'b1;
        @(negedge clk);
        chk(st_dlv == ((NP'(1) << 3) | (NP'(1) << 5)), "R9 both delivered", 64'(st_dlv), 64'h28);
        wait_msg("R9 lowest first", {8'h33, 1'b1, 8'h13, 1'b0, 3'd1});
        wait_msg("R9 next after handshake", {8'h55, 1'b1, 8'h15, 1'b0, 3'd1});
        drive_line(3, 1'b0);
        drive_line(5, 1'b0);
        cfg(3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 3'd0);
        cfg(5, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 3'd0);

        // R2: edge coalesce while request waits, R5 hold
        cfg(4, 1'b0, 1'b0, 1'b0, 1'b1, 8'h44, 8'h11, 3'd0);
        drive_line(4, 1'b1);
        @(negedge clk);
        chk(st_dlv[4] == 1'b1, "R2 edge delivered", 64'(st_dlv[4]), 64'd1);
        line_in[4] = 1'b0;
        drive_line(4, 1'b1);
        @(negedge clk);
        chk(st_coal[4] == 1'b1, "R2 edge coalesced", 64'(st_coal[4]), 64'd1);
        chk(st_dlv[4] == 1'b0, "R2 no second delivery", 64'(st_dlv[4]), 64'd0);
        wait_msg("R5 payload held", {8'h11, 1'b1, 8'h44, 1'b0, 3'd0});
        no_msg("R2 single message", 6);
        drive_line(4, 1'b0);
        cfg(4, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 3'd0);

        // R3 / R7 / R8 / R1: level pin with remote-IRR
        cfg(6, 1'b1, 1'b0, 1'b0, 1'b0, 8'h66, 8'h06, 3'd0);
        drive_line(6, 1'b1);
        wait_msg("R3 level delivered", {8'h06, 1'b0, 8'h66, 1'b1, 3'd0});
        drive_line(6, 1'b0);
        drive_line(6, 1'b1);
        @(negedge clk);
        chk(st_coal[6] == 1'b1, "R3 level coalesced", 64'(st_coal[6]), 64'd1);
        no_msg("R3 no message while remote-IRR", 4);
        eoi(8'h66, 1'b0);
        no_msg("R7 edge-type EOI ignored", 6);
        eoi(8'h67, 1'b1);
        no_msg("R7 unmatched EOI ignored", 6);
        eoi(8'h66, 1'b1);
        wait_msg("R7 EOI re-service", {8'h06, 1'b0, 8'h66, 1'b1, 3'd0});
        wr_pulse(6, 1'b0);
        wait_msg("R8 rewrite re-service", {8'h06, 1'b0, 8'h66, 1'b1, 3'd0});
        drive_line(6, 1'b0);
        wr_pulse(6, 1'b0);
        drive_line(6, 1'b1);
        @(negedge clk);
        chk(st_coal[6] == 1'b1, "R8 high-half write keeps remote-IRR", 64'(st_coal[6]), 64'd1);
        drive_line(6, 1'b0);
        wr_pulse(6, 1'b1);
        drive_line(6, 1'b1);
        @(negedge clk);
        chk(st_dlv[6] == 1'b1, "R8 low-half write clears remote-IRR", 64'(st_dlv[6]), 64'd1);
        wait_msg("R8 delivered after clear", {8'h06, 1'b0, 8'h66, 1'b1, 3'd0});
        drive_line(6, 1'b0);
        eoi(8'h66, 1'b1);
        no_msg("R1 inactive level cleared pending", 6);
        drive_line(6, 1'b1);
        @(negedge clk);
        chk(st_dlv[6] == 1'b1, "R3 delivered after EOI", 64'(st_dlv[6]), 64'd1);
        wait_msg("R3 message after EOI", {8'h06, 1'b0, 8'h66, 1'b1, 3'd0});
        drive_line(6, 1'b0);
        eoi(8'h66, 1'b1);
        cfg(6, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 3'd0);

        // R10: vector map refresh
        cfg(10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h9C, 8'h00, 3'd0);
        chk(vec_map[8'h9C] == 1'b1, "R10 vector marked", 64'(vec_map[8'h9C]), 64'd1);
        chk(vec_map[8'hDD] == 1'b0, "R10 unused vector clear", 64'(vec_map[8'hDD]), 64'd0);
        cfg(10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h9D, 8'h00, 3'd0);
        chk(vec_map[8'h9C] == 1'b0, "R10 old vector dropped", 64'(vec_map[8'h9C]), 64'd0);
        chk(vec_map[8'h9D] == 1'b1, "R10 new vector marked", 64'(vec_map[8'h9D]), 64'd1);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule